// File: doc/BRIEF.md
# Vertical Channel Sequencer for a Dual-Channel Display

This block decides which vertical channel drives a two-channel oscilloscope display in each clock cycle. A three-bit mode selection picks one of four fixed views (channel one, channel two, the sum of both, or X-Y) or one of two switching views. The switching views are alternate, which swaps channels on sweep gate pulses, and chop, which swaps channels on pulses from a free-running chop source. The block drives a two-bit channel-control code and a blanking strobe that hides the beam while a chop switch is in progress. It also drives a trigger-source code that either follows the displayed channel or stays locked to one channel.

A horizontal-alternate flag halves the alternate rate. With that flag set, only every second sweep gate is let through to the channel toggle, so a full two-channel cycle spans four gates. Any change of the mode selection restarts the sequence on channel one. All inputs are sampled on one clock. The sweep gate and the chop input are treated as levels, and only their rising edges act.

Top module: `vseq_top`

## Requirements
- R1: In a fixed mode the channel-control output equals the mode code one clock after it is applied: mode 0 gives 2'b00 (channel one), 1 gives 2'b01 (channel two), 2 gives 2'b10 (sum), 3 gives 2'b11 (X-Y). The unused codes 6 and 7 give 2'b00. Fixed modes never toggle.
- R2: In alternate mode (mode code 4) with the horizontal-alternate flag low, every accepted rising edge of the sweep gate flips the output between 2'b00 and 2'b01, visible one clock after the edge is sampled.
- R3: In alternate mode with the horizontal-alternate flag high, the output flips only on every second accepted sweep gate rising edge. The first gate after the sequence restarts does not flip it.
- R4: In chop mode (mode code 5) each rising edge of the chop input flips the output between 2'b00 and 2'b01, and sweep gate edges have no effect. In alternate mode, chop edges have no effect.
- R5: Each accepted chop edge raises the blanking output for exactly BLANK_CYCLES clocks (default 4), starting one clock after the edge is sampled. A new chop edge while blanking is active restarts the full count. Blanking is never raised outside chop mode.
- R6: Trigger-select code 0 or 3 (follow) makes the trigger-source output equal the channel-control output. Code 1 forces 2'b00 and code 2 forces 2'b01, whatever the sequencer state.
- R7: A change of the mode selection clears the channel toggle and the halving stage, so the output after the change into a switching mode is 2'b00 and the halving stage starts over.
- R8: A sweep gate or chop rising edge sampled in the same clock as a mode change is ignored: it neither flips the channel nor starts blanking.
- R9: A synchronous active-high reset forces the channel-control output to 2'b00, clears blanking and clears the halving stage.
- R10: A sweep gate held high for several clocks acts once, at its rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| modeSel | input | 3 | Display mode: 0 ch1, 1 ch2, 2 sum, 3 X-Y, 4 alternate, 5 chop |
| horizAlt | input | 1 | Horizontal alternate flag; halves the alternate rate |
| sweepGate | input | 1 | Sweep gate level; rising edge advances alternate mode |
| chopTick | input | 1 | Chop source level; rising edge advances chop mode |
| trigSel | input | 2 | Trigger select: 0/3 follow, 1 lock ch1, 2 lock ch2 |
| chanCtl | output | 2 | Channel-control code for the vertical switch |
| blank | output | 1 | Beam blanking during a chop switch |
| trigSrc | output | 2 | Trigger-source code |

## Verification
A toggle bit out of step with the gate history shows up as the wrong channel on the first flip after it goes wrong, within one gate or chop edge. A stale halving stage shows up on the next pair of gates, where the flip lands one gate early or late. A blanking counter fault shows up as a pulse that is one or more clocks too long or too short on the very next chop edge. The scoreboard compares all three outputs every cycle against a model built from the requirements, so any such divergence is reported in the cycle it first reaches a port.

// File: rtl/vseq_pkg.sv
package vseq_pkg;

  typedef enum logic [2:0] {
    MODE_CH1  = 3'd0,
    MODE_CH2  = 3'd1,
    MODE_SUM  = 3'd2,
    MODE_XY   = 3'd3,
    MODE_ALT  = 3'd4,
    MODE_CHOP = 3'd5
  } viewMode_e;

  typedef enum logic [1:0] {
    TRIG_FOLLOW  = 2'd0,
    TRIG_LOCK1   = 2'd1,
    TRIG_LOCK2   = 2'd2,
    TRIG_FOLLOW2 = 2'd3
  } trigMode_e;

  // Strobes from control to datapath, valid for one cycle
  typedef struct packed {
    logic       clearSeq;   // restart sequence on channel one
    logic       flipChan;   // swap displayed channel
    logic       startBlank; // (re)load blanking counter
    logic       useToggle;  // switching mode: output follows toggle
    logic [1:0] fixedCode;  // code used in fixed modes
  } seqStrobe_t;

endpackage

// File: rtl/vseq_edge.sv
module vseq_edge (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise
);
  logic prevQ;

  always_ff @(posedge clk) begin
    if (rst) prevQ <= 1'b0;
    else     prevQ <= din;
  end

  assign rise = din & ~prevQ;
endmodule

// File: rtl/vseq_ctrl.sv
module vseq_ctrl
  import vseq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] modeSel,
  input  logic       horizAlt,
  input  logic       sweepGate,
  input  logic       chopTick,
  output seqStrobe_t strb
);
  localparam int NUM_PULSE = 2;

  logic [NUM_PULSE-1:0] pulseIn;
  logic [NUM_PULSE-1:0] pulseRise;
  logic [2:0] prevMode;
  logic       divQ;
  logic       divNext;
  logic       modeChange;
  logic       isAlt;
  logic       isChop;
  logic       gateOk;
  logic       chopOk;

  assign pulseIn = {chopTick, sweepGate};

  for (genvar i = 0; i < NUM_PULSE; i++) begin : g_edge
    vseq_edge uEdge (
      .clk  (clk),
      .rst  (rst),
      .din  (pulseIn[i]),
      .rise (pulseRise[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prevMode <= modeSel;
      divQ     <= 1'b0;
    end else begin
      prevMode <= modeSel;
      divQ     <= divNext;
    end
  end

  always_comb begin
    modeChange = (modeSel != prevMode);
    isAlt      = (modeSel == MODE_ALT);
    isChop     = (modeSel == MODE_CHOP);
    gateOk     = pulseRise[0] & isAlt & ~modeChange;
    chopOk     = pulseRise[1] & isChop & ~modeChange;

    if (modeChange)             divNext = 1'b0;
    else if (gateOk & horizAlt) divNext = ~divQ;
    else                        divNext = divQ;

    strb.clearSeq   = modeChange;
    strb.flipChan   = chopOk | (gateOk & (~horizAlt | divQ));
    strb.startBlank = chopOk;
    strb.useToggle  = isAlt | isChop;
    strb.fixedCode  = (modeSel <= MODE_XY) ? modeSel[1:0] : 2'b00;
  end
endmodule

// File: rtl/vseq_datapath.sv
module vseq_datapath
  import vseq_pkg::*;
#(
  parameter int BLANK_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  seqStrobe_t strb,
  input  logic [1:0] trigSel,
  output logic [1:0] chanCtl,
  output logic       blank,
  output logic [1:0] trigSrc
);
  localparam int CNT_W = $clog2(BLANK_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(BLANK_CYCLES);

  logic             toggleQ;
  logic             toggleNext;
  logic [1:0]       chanQ;
  logic [1:0]       chanNext;
  logic [CNT_W-1:0] cntQ;

  always_comb begin
    toggleNext = strb.clearSeq ? 1'b0 : (toggleQ ^ strb.flipChan);
    chanNext   = strb.useToggle ? {1'b0, toggleNext} : strb.fixedCode;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      toggleQ <= 1'b0;
      chanQ   <= 2'b00;
      cntQ    <= '0;
    end else begin
      toggleQ <= toggleNext;
      chanQ   <= chanNext;
      if (strb.startBlank)  cntQ <= CNT_LOAD;
      else if (cntQ != '0)  cntQ <= cntQ - 1'b1;
    end
  end

  always_comb begin
    case (trigSel)
      TRIG_LOCK1: trigSrc = 2'b00;
      TRIG_LOCK2: trigSrc = 2'b01;
      default:    trigSrc = chanQ;
    endcase
  end

  assign chanCtl = chanQ;
  assign blank   = (cntQ != '0);
endmodule

// File: rtl/vseq_top.sv
module vseq_top
  import vseq_pkg::*;
#(
  parameter int BLANK_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] modeSel,
  input  logic       horizAlt,
  input  logic       sweepGate,
  input  logic       chopTick,
  input  logic [1:0] trigSel,
  output logic [1:0] chanCtl,
  output logic       blank,
  output logic [1:0] trigSrc
);
  seqStrobe_t strb;

  vseq_ctrl uCtrl (
    .clk       (clk),
    .rst       (rst),
    .modeSel   (modeSel),
    .horizAlt  (horizAlt),
    .sweepGate (sweepGate),
    .chopTick  (chopTick),
    .strb      (strb)
  );

  vseq_datapath #(.BLANK_CYCLES(BLANK_CYCLES)) uData (
    .clk     (clk),
    .rst     (rst),
    .strb    (strb),
    .trigSel (trigSel),
    .chanCtl (chanCtl),
    .blank   (blank),
    .trigSrc (trigSrc)
  );
endmodule

// File: rtl/vseq_chk.sv
module vseq_chk
  import vseq_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic [2:0] modeSel,
  input logic [1:0] trigSel,
  input logic [1:0] chanCtl,
  input logic       blank,
  input logic [1:0] trigSrc
);
  logic armed  = 1'b0;
  logic armed2 = 1'b0;

  always_ff @(posedge clk) begin
    armed  <= !rst;
    armed2 <= armed && !rst;
  end

  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (chanCtl == 2'b00 && !blank)); // R9

  AST_FIXED_CODE: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(modeSel) <= MODE_XY) |-> chanCtl == $past(modeSel[1:0])); // R1

  AST_SWITCH_RANGE: assert property (@(posedge clk) disable iff (rst)
    (armed && ($past(modeSel) == MODE_ALT || $past(modeSel) == MODE_CHOP)) |-> !chanCtl[1]); // R2

  AST_BLANK_FLIPS: assert property (@(posedge clk) disable iff (rst)
    (armed2 && $rose(blank)) |-> chanCtl != $past(chanCtl)); // R4

  AST_BLANK_IN_CHOP: assert property (@(posedge clk) disable iff (rst)
    (armed2 && $rose(blank)) |-> $past(modeSel) == MODE_CHOP); // R5

  AST_TRIG_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    (trigSel == TRIG_FOLLOW || trigSel == TRIG_FOLLOW2) |-> trigSrc == chanCtl); // R6

  AST_TRIG_LOCK: assert property (@(posedge clk) disable iff (rst)
    (trigSel == TRIG_LOCK1 || trigSel == TRIG_LOCK2) |-> trigSrc == {1'b0, trigSel[1]}); // R6

  AST_MODECHG_CH1: assert property (@(posedge clk) disable iff (rst)
    (armed2 && $past(modeSel) != $past(modeSel, 2) &&
     ($past(modeSel) == MODE_ALT || $past(modeSel) == MODE_CHOP)) |-> chanCtl == 2'b00); // R7
endmodule

bind vseq_top vseq_chk uChk (
  .clk     (clk),
  .rst     (rst),
  .modeSel (modeSel),
  .trigSel (trigSel),
  .chanCtl (chanCtl),
  .blank   (blank),
  .trigSrc (trigSrc)
);

// File: tb/tb_vseq_top.sv
`timescale 1ns/1ps
module tb_vseq_top;
  localparam int BLANK = 4;

  logic       clk = 1'b0;
  logic       rst;
  logic [2:0] modeSel;
  logic       horizAlt;
  logic       sweepGate;
  logic       chopTick;
  logic [1:0] trigSel;
  logic [1:0] chanCtl;
  logic       blank;
  logic [1:0] trigSrc;

  always #2 clk = ~clk;

  vseq_top #(.BLANK_CYCLES(BLANK)) dut (
    .clk(clk), .rst(rst), .modeSel(modeSel), .horizAlt(horizAlt),
    .sweepGate(sweepGate), .chopTick(chopTick), .trigSel(trigSel),
    .chanCtl(chanCtl), .blank(blank), .trigSrc(trigSrc)
  );

  int   checks = 0;
  int   errors = 0;
  bit   done   = 0;
  logic [4:0] expQ[$];
  string      tagQ[$];

  // reference model state, built from the requirements
  logic       mTog, mDiv, mPg, mPc;
  logic [2:0] mPrevMode;
  logic [1:0] mChan;
  int         mCnt;

  // driver: inputs are already set; predict outputs after the next edge
  task automatic step(string tag);
    logic mc, gr, cr, flip, start;
    logic [1:0] tr;
    if (rst) begin
      mTog = 0; mDiv = 0; mCnt = 0; mChan = 2'b00;
      mPg = 0; mPc = 0; mPrevMode = modeSel;
    end else begin
      mc = (modeSel != mPrevMode);
      gr = sweepGate && !mPg;
      cr = chopTick && !mPc;
      flip = 0; start = 0;
      if (mc) begin
        mTog = 0; mDiv = 0;
      end else if (modeSel == 3'd4 && gr) begin
        if (horizAlt) begin flip = mDiv; mDiv = ~mDiv; end
        else flip = 1;
      end else if (modeSel == 3'd5 && cr) begin
        flip = 1; start = 1;
      end
      if (start) mCnt = BLANK;
      else if (mCnt > 0) mCnt = mCnt - 1;
      if (flip) mTog = ~mTog;
      if (modeSel == 3'd4 || modeSel == 3'd5) mChan = {1'b0, mTog};
      else if (modeSel <= 3'd3) mChan = modeSel[1:0];
      else mChan = 2'b00;
      mPg = sweepGate; mPc = chopTick; mPrevMode = modeSel;
    end
    tr = (trigSel == 2'd1) ? 2'b00 : (trigSel == 2'd2) ? 2'b01 : mChan;
    expQ.push_back({mChan, (mCnt != 0), tr});
    tagQ.push_back(tag);
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic steps(int n, string tag);
    for (int i = 0; i < n; i++) step(tag);
  endtask

  task automatic gatePulse(string tag);
    sweepGate = 1; step(tag);
    sweepGate = 0; step(tag);
  endtask

  task automatic chopPulse(string tag);
    chopTick = 1; step(tag);
    chopTick = 0; step(tag);
  endtask

  // monitor: compare after each edge
  always @(posedge clk) begin : monitor
    logic [4:0] e;
    string      t;
    #1;
    while (expQ.size() > 0) begin
      e = expQ.pop_front();
      t = tagQ.pop_front();
      checks++;
      if ({chanCtl, blank, trigSrc} !== e) begin
        errors++;
        $display("FAIL %s: chan=%b blank=%b trig=%b expected chan=%b blank=%b trig=%b",
                 t, chanCtl, blank, trigSrc, e[4:3], e[2], e[1:0]);
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1; modeSel = 3'd0; horizAlt = 0; sweepGate = 0; chopTick = 0; trigSel = 2'd0;
    @(negedge clk);
    steps(3, "R9 reset state");
    rst = 0;

    // fixed modes and trigger select
    modeSel = 3'd1; steps(2, "R1 mode ch2");
    modeSel = 3'd2; steps(2, "R1 mode sum");
    modeSel = 3'd3; steps(2, "R1 mode xy");
    modeSel = 3'd6; steps(2, "R1 unused code");
    modeSel = 3'd3;
    trigSel = 2'd1; steps(2, "R6 lock ch1");
    trigSel = 2'd2; steps(2, "R6 lock ch2");
    trigSel = 2'd3; steps(2, "R6 follow code 3");
    trigSel = 2'd0;
    gatePulse("R1 fixed ignores gate");
    chopPulse("R1 fixed ignores chop");

    // alternate, no horizontal alternate
    modeSel = 3'd4; steps(2, "R7 enter alternate");
    for (int k = 0; k < 3; k++) gatePulse("R2 alternate flip");
    chopPulse("R4 chop ignored in alternate");
    sweepGate = 1; steps(4, "R10 held gate");
    sweepGate = 0; step("R10 gate release");
    trigSel = 2'd2; gatePulse("R6 locked while alternating");
    trigSel = 2'd0;

    // alternate with horizontal alternate
    horizAlt = 1;
    for (int k = 0; k < 5; k++) gatePulse("R3 every second gate");

    // mode change clears halving stage
    modeSel = 3'd5; steps(2, "R7 change to chop");
    modeSel = 3'd4; steps(2, "R7 back to alternate");
    gatePulse("R7 first gate after restart");
    gatePulse("R3 second gate flips");

    // chop mode; edge in mode-change cycle ignored
    horizAlt = 0;
    modeSel = 3'd5; chopTick = 1; step("R8 chop on mode change");
    chopTick = 0; steps(2, "R8 no blank after ignored chop");
    chopPulse("R4 chop flip");
    steps(5, "R5 blank length");
    gatePulse("R4 gate ignored in chop");
    chopPulse("R5 first chop");
    chopPulse("R5 retrigger");
    steps(6, "R5 retrigger length");
    trigSel = 2'd3; chopPulse("R6 follow in chop");
    trigSel = 2'd1; steps(5, "R6 lock in chop");
    trigSel = 2'd0;

    // gate edge in mode-change cycle ignored
    modeSel = 3'd4; sweepGate = 1; step("R8 gate on mode change");
    sweepGate = 0; step("R8 gate ignored");
    gatePulse("R2 next gate flips");

    // reset while blanking
    modeSel = 3'd5; steps(2, "R7 into chop");
    chopPulse("R4 chop before reset");
    rst = 1; steps(2, "R9 reset clears blank");
    rst = 0; steps(2, "R9 after reset");

    steps(1, "final");
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule